// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Front End

This block is the serial slave side of a small three-wire serial EEPROM model. It watches a select line, a serial clock and a serial data input, all sampled by a faster system clock, and drives a serial data output with its own output-enable. It frames each instruction (a start bit, an opcode, an address and, for the two data-carrying instructions, a data word) and decodes it. Reads are served from a word array that sits outside this block. The array is reached through a combinational read port, and a read keeps streaming words with the address counting up for as long as the host keeps clocking.

Program operations (single-word write, single-word erase, erase of the whole array, write of the whole array) are never carried out here. When a complete program frame ends with the select line falling and writes are enabled, the block hands a one-cycle request with its kind, address and data to a separate program sequencer. While that request is outstanding, the block shows the sequencer's busy state on the data output whenever the host selects it. A width input chooses 16-bit words (64 of them) or 8-bit words (128 of them). The select, serial clock and data inputs are taken to be already synchronous to the system clock.

Top module: `sereep_front`

## Requirements
- R1: With `org_wide` high the array is 64 words of 16 bits and the frame carries a 6-bit address. With it low the array is 128 words of 8 bits and the frame carries a 7-bit address, and only `arr_word[7:0]` is used.
- R2: `sdi` is sampled on each rising edge of `sclk`. Zeros clocked in before the first 1 are ignored. The first 1 is the start bit and is followed by a 2-bit opcode and then the address, MSB first.
- R3: Opcode 10 is a read. On the rising edge that delivers the last address bit, `sdo_en` goes high and `sdo` shows a single 0. Each later rising edge shifts out one bit of the addressed word, MSB first.
- R4: When a read word ends and `sel` is still high, the next word (address plus one) follows at once with no extra 0. After the highest address the read wraps to address 0.
- R5: Opcode 00 takes the top two address bits as a sub-code: 11 enables writes, 00 disables writes, 10 erases everything and 01 writes everything. The enable is cleared by reset and by the disable sub-code. While writes are disabled, no program request is ever made.
- R6: Opcode 01 (write one word, followed by a data word MSB first) and 11 (erase one word) are program frames, as are the erase-all and write-all sub-codes. When a complete program frame ends with `sel` falling and writes are enabled, `pg_req` pulses and `pg_kind` carries the kind: 0 write, 1 erase, 2 erase-all, 3 write-all. `pg_addr` carries the address, and `pg_data` carries the word, zero-extended in 8-bit mode.
- R7: A frame that `sel` ends before all of its bits have arrived is dropped without a request, and the next frame decodes normally.
- R8: After a request, every time `sel` is high the output is enabled and shows the inverse of `pg_busy`: 0 while busy, 1 when ready.
- R9: While the status is shown, a 1 clocked in during the ready state turns the output off on that edge. Bits clocked in while busy change nothing, and no new frame starts until the status has been turned off.
- R10: While `sel` is low, `sdo_en` is low and the frame decoder is back in its idle state. After reset, `sdo_en` and `pg_req` are low.
- R11: Reads work whatever the state of the write enable.
- R12: `pg_req` lasts one system clock, and `pg_addr`, `pg_kind` and `pg_data` change only when a request is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| org_wide | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| sel | input | 1 | Select, active high, frames an instruction |
| sclk | input | 1 | Serial clock, sampled by clk |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out: read data or ready status |
| sdo_en | output | 1 | Output enable for sdo |
| arr_addr | output | 7 | Word address on the array read port |
| arr_word | input | 16 | Word returned by the array for arr_addr |
| pg_req | output | 1 | One-cycle program request |
| pg_kind | output | 2 | Request kind: 0 write, 1 erase, 2 erase-all, 3 write-all |
| pg_addr | output | 7 | Request word address |
| pg_data | output | 16 | Request data word |
| pg_busy | input | 1 | Program sequencer is busy |

## Verification
The checks take it for granted that `sel`, `sclk` and `sdi` change only between system clock edges and are already synchronous. They assume `sel` never falls on the same system clock as a serial clock edge, and that `pg_busy` rises within one cycle of `pg_req`, well before the host selects the block again. The stimulus holds every serial level for several system clocks. It drops `sel` only with `sclk` low, and it leaves at least four system clocks between the falling select that makes a request and the next rise. The bench's sequencer model raises busy on the cycle after a request, so all of these assumptions are met throughout the test.

// File: rtl/sereep_pkg.sv
package sereep_pkg;

   typedef enum logic [1:0] {
      PK_WRITE = 2'd0,
      PK_ERASE = 2'd1,
      PK_ERAL  = 2'd2,
      PK_WRAL  = 2'd3
   } pg_kind_t;

   typedef enum logic [2:0] {
      FS_IDLE,
      FS_HDR,
      FS_DATA,
      FS_READ,
      FS_DONE
   } fstate_t;

   localparam logic [1:0] OP_SPECIAL = 2'b00;
   localparam logic [1:0] OP_WRITE   = 2'b01;
   localparam logic [1:0] OP_READ    = 2'b10;
   localparam logic [1:0] OP_ERASE   = 2'b11;

   localparam logic [1:0] SUB_WDIS = 2'b00;
   localparam logic [1:0] SUB_WRAL = 2'b01;
   localparam logic [1:0] SUB_ERAL = 2'b10;
   localparam logic [1:0] SUB_WEN  = 2'b11;

endpackage

// File: rtl/sereep_edges.sv
module sereep_edges (
   input  logic clk,
   input  logic rst_n,
   input  logic sel,
   input  logic sclk,
   output logic sk_rise,
   output logic sel_fall
);
   logic sel_q;
   logic sk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= 1'b0;
         sk_q  <= 1'b0;
      end else begin
         sel_q <= sel;
         sk_q  <= sclk;
      end
   end

   assign sk_rise  = sclk & ~sk_q;
   assign sel_fall = ~sel & sel_q;
endmodule

// File: rtl/sereep_frame.sv
module sereep_frame
   import sereep_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int AW     = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              sk_rise,
   input  logic              sdi,
   input  logic              wide,
   input  logic              hold,
   input  logic [WORD_W-1:0] arr_word,
   output logic [AW-1:0]     arr_addr,
   output logic              rd_oe,
   output logic              rd_bit,
   output logic              set_wen,
   output logic              clr_wen,
   output logic              pend_v,
   output pg_kind_t          pend_kind,
   output logic [AW-1:0]     pend_addr,
   output logic [WORD_W-1:0] pend_data
);
   localparam int HDR_MAX = 2 + AW;
   localparam int CNT_MAX = (HDR_MAX > WORD_W) ? HDR_MAX : WORD_W;
   localparam int CW      = $clog2(CNT_MAX) + 1;
   localparam int BW      = $clog2(WORD_W);

   fstate_t           st;
   logic [CW-1:0]     cnt;
   logic [1:0]        op;
   logic [AW-1:0]     addr;
   logic [WORD_W-1:0] dsh;

   logic [CW-1:0]     hdr_last;
   logic [CW-1:0]     wlast;
   logic [AW-1:0]     amask;
   logic [AW-1:0]     a_n;
   logic [1:0]        sub;

   always_comb begin
      hdr_last = wide ? CW'(HDR_MAX - 2) : CW'(HDR_MAX - 1);
      wlast    = wide ? CW'(WORD_W - 1) : CW'(WORD_W / 2 - 1);
      amask    = wide ? {1'b0, {(AW-1){1'b1}}} : {AW{1'b1}};
      a_n      = {addr[AW-2:0], sdi};
      sub      = wide ? a_n[AW-2 -: 2] : a_n[AW-1 -: 2];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= FS_IDLE;
         cnt       <= '0;
         op        <= '0;
         addr      <= '0;
         dsh       <= '0;
         rd_oe     <= 1'b0;
         rd_bit    <= 1'b0;
         set_wen   <= 1'b0;
         clr_wen   <= 1'b0;
         pend_v    <= 1'b0;
         pend_kind <= PK_WRITE;
      end else begin
         set_wen <= 1'b0;
         clr_wen <= 1'b0;
         if (!sel) begin
            st     <= FS_IDLE;
            rd_oe  <= 1'b0;
            pend_v <= 1'b0;
         end else if (sk_rise) begin
            case (st)
               FS_IDLE: begin
                  if (sdi && !hold) begin
                     st   <= FS_HDR;
                     cnt  <= '0;
                     op   <= '0;
                     addr <= '0;
                     dsh  <= '0;
                  end
               end
               FS_HDR: begin
                  cnt <= cnt + CW'(1);
                  if (cnt < CW'(2)) op <= {op[0], sdi};
                  else              addr <= a_n;
                  if (cnt == hdr_last) begin
                     addr <= a_n & amask;
                     st   <= FS_DONE;
                     case (op)
                        OP_READ: begin
                           st     <= FS_READ;
                           rd_oe  <= 1'b1;
                           rd_bit <= 1'b0;
                           cnt    <= wlast;
                        end
                        OP_ERASE: begin
                           pend_kind <= PK_ERASE;
                           pend_v    <= 1'b1;
                        end
                        OP_WRITE: begin
                           pend_kind <= PK_WRITE;
                           st        <= FS_DATA;
                           cnt       <= wlast;
                        end
                        default: begin
                           case (sub)
                              SUB_WEN:  set_wen <= 1'b1;
                              SUB_WDIS: clr_wen <= 1'b1;
                              SUB_ERAL: begin
                                 pend_kind <= PK_ERAL;
                                 pend_v    <= 1'b1;
                              end
                              default: begin
                                 pend_kind <= PK_WRAL;
                                 st        <= FS_DATA;
                                 cnt       <= wlast;
                              end
                           endcase
                        end
                     endcase
                  end
               end
               FS_DATA: begin
                  dsh <= {dsh[WORD_W-2:0], sdi};
                  if (cnt == '0) begin
                     pend_v <= 1'b1;
                     st     <= FS_DONE;
                  end else begin
                     cnt <= cnt - CW'(1);
                  end
               end
               FS_READ: begin
                  rd_bit <= arr_word[cnt[BW-1:0]];
                  if (cnt == '0) begin
                     addr <= (addr + AW'(1)) & amask;
                     cnt  <= wlast;
                  end else begin
                     cnt <= cnt - CW'(1);
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign arr_addr  = addr;
   assign pend_addr = addr;
   assign pend_data = dsh;
endmodule

// File: rtl/sereep_ctl.sv
module sereep_ctl
   import sereep_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int AW     = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              sel_fall,
   input  logic              sk_rise,
   input  logic              sdi,
   input  logic              set_wen,
   input  logic              clr_wen,
   input  logic              pend_v,
   input  pg_kind_t          pend_kind,
   input  logic [AW-1:0]     pend_addr,
   input  logic [WORD_W-1:0] pend_data,
   input  logic              pg_busy,
   output logic              wen,
   output logic              stat_on,
   output logic              stat_drop,
   output logic              pg_req,
   output logic [1:0]        pg_kind,
   output logic [AW-1:0]     pg_addr,
   output logic [WORD_W-1:0] pg_data
);
   assign stat_drop = stat_on & sel & sk_rise & sdi & ~pg_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wen     <= 1'b0;
         stat_on <= 1'b0;
         pg_req  <= 1'b0;
         pg_kind <= '0;
         pg_addr <= '0;
         pg_data <= '0;
      end else begin
         pg_req <= 1'b0;
         if (set_wen)      wen <= 1'b1;
         else if (clr_wen) wen <= 1'b0;
         if (sel_fall && pend_v && wen) begin
            pg_req  <= 1'b1;
            pg_kind <= pend_kind;
            pg_addr <= pend_addr;
            pg_data <= pend_data;
            stat_on <= 1'b1;
         end else if (stat_drop) begin
            stat_on <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sereep_dout.sv
module sereep_dout (
   input  logic clk,
   input  logic rst_n,
   input  logic sel,
   input  logic stat_on,
   input  logic stat_drop,
   input  logic pg_busy,
   input  logic rd_oe,
   input  logic rd_bit,
   output logic sdo,
   output logic sdo_en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sdo    <= 1'b0;
         sdo_en <= 1'b0;
      end else if (!sel) begin
         sdo    <= 1'b0;
         sdo_en <= 1'b0;
      end else if (stat_on && !stat_drop) begin
         sdo    <= ~pg_busy;
         sdo_en <= 1'b1;
      end else if (rd_oe) begin
         sdo    <= rd_bit;
         sdo_en <= 1'b1;
      end else begin
         sdo    <= 1'b0;
         sdo_en <= 1'b0;
      end
   end
endmodule

// File: rtl/sereep_front.sv
module sereep_front
   import sereep_pkg::*;
#(
   parameter int TOTAL_BITS = 1024,
   parameter int WORD_W     = 16,
   parameter int ORG_MODE   = 0,
   localparam int AW        = $clog2(TOTAL_BITS / (WORD_W / 2))
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              org_wide,
   input  logic              sel,
   input  logic              sclk,
   input  logic              sdi,
   output logic              sdo,
   output logic              sdo_en,
   output logic [AW-1:0]     arr_addr,
   input  logic [WORD_W-1:0] arr_word,
   output logic              pg_req,
   output logic [1:0]        pg_kind,
   output logic [AW-1:0]     pg_addr,
   output logic [WORD_W-1:0] pg_data,
   input  logic              pg_busy
);
   if (WORD_W < 4 || (WORD_W % 2) != 0) begin : g_bad_word
      $error("sereep_front: WORD_W must be even and at least 4");
   end
   if ((TOTAL_BITS & (TOTAL_BITS - 1)) != 0 || TOTAL_BITS < 8 * WORD_W) begin : g_bad_size
      $error("sereep_front: TOTAL_BITS must be a power of two of at least 8 words");
   end
   if (ORG_MODE < 0 || ORG_MODE > 2) begin : g_bad_org
      $error("sereep_front: ORG_MODE must be 0, 1 or 2");
   end

   logic wide;
   if (ORG_MODE == 1) begin : g_fixed_wide
      assign wide = 1'b1;
   end else if (ORG_MODE == 2) begin : g_fixed_narrow
      assign wide = 1'b0;
   end else begin : g_pin_org
      assign wide = org_wide;
   end

   logic              sk_rise, sel_fall;
   logic              rd_oe, rd_bit, set_wen, clr_wen, pend_v;
   pg_kind_t          pend_kind;
   logic [AW-1:0]     pend_addr;
   logic [WORD_W-1:0] pend_data;
   logic              wen, stat_on, stat_drop;

   sereep_edges u_edges (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel      (sel),
      .sclk     (sclk),
      .sk_rise  (sk_rise),
      .sel_fall (sel_fall)
   );

   sereep_frame #(.WORD_W(WORD_W), .AW(AW)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel),
      .sk_rise   (sk_rise),
      .sdi       (sdi),
      .wide      (wide),
      .hold      (stat_on),
      .arr_word  (arr_word),
      .arr_addr  (arr_addr),
      .rd_oe     (rd_oe),
      .rd_bit    (rd_bit),
      .set_wen   (set_wen),
      .clr_wen   (clr_wen),
      .pend_v    (pend_v),
      .pend_kind (pend_kind),
      .pend_addr (pend_addr),
      .pend_data (pend_data)
   );

   sereep_ctl #(.WORD_W(WORD_W), .AW(AW)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel),
      .sel_fall  (sel_fall),
      .sk_rise   (sk_rise),
      .sdi       (sdi),
      .set_wen   (set_wen),
      .clr_wen   (clr_wen),
      .pend_v    (pend_v),
      .pend_kind (pend_kind),
      .pend_addr (pend_addr),
      .pend_data (pend_data),
      .pg_busy   (pg_busy),
      .wen       (wen),
      .stat_on   (stat_on),
      .stat_drop (stat_drop),
      .pg_req    (pg_req),
      .pg_kind   (pg_kind),
      .pg_addr   (pg_addr),
      .pg_data   (pg_data)
   );

   sereep_dout u_dout (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel),
      .stat_on   (stat_on),
      .stat_drop (stat_drop),
      .pg_busy   (pg_busy),
      .rd_oe     (rd_oe),
      .rd_bit    (rd_bit),
      .sdo       (sdo),
      .sdo_en    (sdo_en)
   );
endmodule

// File: rtl/sereep_front_chk.sv
module sereep_front_chk #(
   parameter int AW = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sel,
   input logic          sdo_en,
   input logic          wen,
   input logic          pg_req,
   input logic [AW-1:0] pg_addr
);
   AST_HIZ_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> !sdo_en); // R10

   AST_REQ_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
      pg_req |-> wen); // R5

   AST_WEN_SET_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wen) |-> $past(sel, 2)); // R5

   AST_REQ_AT_SEL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      pg_req |-> (!$past(sel) && $past(sel, 2))); // R6

   AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      pg_req |=> !pg_req); // R12

   AST_REQ_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !pg_req |-> $stable(pg_addr)); // R12
endmodule

bind sereep_front sereep_front_chk #(.AW(AW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sel     (sel),
   .sdo_en  (sdo_en),
   .wen     (wen),
   .pg_req  (pg_req),
   .pg_addr (pg_addr)
);

// File: tb/tb_sereep_front.sv
`timescale 1ns/1ps
module tb_sereep_front;
   localparam int AW = 7;
   localparam int WW = 16;

   typedef struct packed {
      logic [1:0]    k;
      logic [AW-1:0] a;
      logic [WW-1:0] d;
   } req_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          org_wide = 1'b1;
   logic          sel = 1'b0;
   logic          sclk = 1'b0;
   logic          sdi = 1'b0;
   logic          sdo, sdo_en, pg_req, pg_busy;
   logic [AW-1:0] arr_addr, pg_addr;
   logic [WW-1:0] arr_word, pg_data, pw;
   logic [1:0]    pg_kind;

   int n_chk = 0;
   int n_fail = 0;
   int bcnt;
   bit done = 1'b0;
   bit prev_req = 1'b0;
   req_t exp_q[$];

   always #2.5 clk = ~clk;

   function automatic logic [WW-1:0] patt(input int a);
      return WW'((a * 4951) ^ 50085);
   endfunction

   assign pw       = patt(int'(arr_addr));
   assign arr_word = org_wide ? pw : {8'h00, pw[7:0]};
   assign pg_busy  = (bcnt != 0);

   always_ff @(posedge clk) begin
      if (!rst_n)           bcnt <= 0;
      else if (pg_req)      bcnt <= 40;
      else if (bcnt != 0)   bcnt <= bcnt - 1;
   end

   sereep_front dut (
      .clk(clk), .rst_n(rst_n), .org_wide(org_wide), .sel(sel), .sclk(sclk), .sdi(sdi),
      .sdo(sdo), .sdo_en(sdo_en), .arr_addr(arr_addr), .arr_word(arr_word),
      .pg_req(pg_req), .pg_kind(pg_kind), .pg_addr(pg_addr), .pg_data(pg_data),
      .pg_busy(pg_busy)
   );

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: %s actual %h expected %h", rq, what, act, exp);
      end
   endtask

   // scoreboard monitor: pops the expected request for every pulse (R6, R12)
   always @(negedge clk) begin
      if (rst_n && pg_req) begin
         req_t e;
         n_chk++;
         if (prev_req) begin
            n_fail++;
            $display("FAIL R12: pg_req high two cycles actual 1 expected 0");
         end else if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R6: unexpected request actual k=%0d a=%h expected none", pg_kind, pg_addr);
         end else begin
            e = exp_q.pop_front();
            if (pg_kind !== e.k ||
                ((e.k == 2'd0 || e.k == 2'd1) && pg_addr !== e.a) ||
                ((e.k == 2'd0 || e.k == 2'd3) && pg_data !== e.d)) begin
               n_fail++;
               $display("FAIL R6: request actual k=%0d a=%h d=%h expected k=%0d a=%h d=%h",
                        pg_kind, pg_addr, pg_data, e.k, e.a, e.d);
            end
         end
      end
      prev_req = rst_n && pg_req;
   end

   task automatic bitx(input logic b, output logic o, output logic oe);
      @(negedge clk) sdi = b;
      repeat (2) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      o  = sdo;
      oe = sdo_en;
      sclk = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic send_bits(input logic [31:0] v, input int n);
      logic o, oe;
      for (int i = n - 1; i >= 0; i--) bitx(v[i], o, oe);
   endtask

   task automatic sel_up;
      @(negedge clk) sel = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic sel_down;
      @(negedge clk) sel = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic cmd(input logic [1:0] op, input logic [AW-1:0] a, input int abits);
      send_bits({29'd0, 1'b1, op}, 3);
      send_bits({25'd0, a}, abits);
   endtask

   task automatic rd_word(input int n, output logic [WW-1:0] w);
      logic o, oe;
      w = '0;
      for (int i = 0; i < n; i++) begin
         bitx(1'b0, o, oe);
         w = {w[WW-2:0], o};
      end
   endtask

   // read frame; last address bit returns the dummy bit
   task automatic start_read(input logic [AW-1:0] a, input int abits, input string rq);
      logic o, oe;
      send_bits({29'd0, 3'b110}, 3);
      send_bits({25'd0, a} >> 1, abits - 1);
      bitx(a[0], o, oe);
      chk(rq, {30'd0, oe, o}, 32'h2, "dummy bit {oe,sdo}");
   endtask

   task automatic finish_req;
      logic o, oe;
      while (pg_busy) @(negedge clk);
      sel_up;
      bitx(1'b1, o, oe);
      chk("R9", {31'd0, oe}, 32'd0, "sdo_en after ready 1");
      sel_down;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run hung actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [WW-1:0] w;
      logic o, oe;
      repeat (4) @(negedge clk);
      chk("R10", {30'd0, sdo_en, pg_req}, 32'd0, "reset outputs");
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R2 R3 R11: read with leading zeros, writes disabled
      sel_up;
      send_bits(32'd0, 2);
      start_read(7'd5, 6, "R3");
      rd_word(16, w); chk("R3", 32'(w), 32'(patt(5)), "word at 5");
      rd_word(16, w); chk("R4", 32'(w), 32'(patt(6)), "sequential word 6");
      sel_down;
      chk("R10", {31'd0, sdo_en}, 32'd0, "sdo_en after deselect");

      // R4 wrap in 16-bit mode
      sel_up;
      start_read(7'd63, 6, "R3");
      rd_word(16, w); chk("R11", 32'(w), 32'(patt(63)), "word at 63");
      rd_word(16, w); chk("R4", 32'(w), 32'(patt(0)), "wrap to 0");
      sel_down;

      // R5: write while disabled makes no request and no status
      sel_up; cmd(2'b01, 7'd9, 6); send_bits(32'hBEEF, 16); sel_down;
      repeat (10) @(negedge clk);
      sel_up;
      chk("R5", {31'd0, sdo_en}, 32'd0, "no status when writes disabled");
      sel_down;

      // enable, then single-word write (R6) and status (R8, R9)
      sel_up; cmd(2'b00, 7'b0110000, 6); sel_down;
      exp_q.push_back('{k: 2'd0, a: 7'd9, d: 16'hBEEF});
      sel_up; cmd(2'b01, 7'd9, 6); send_bits(32'hBEEF, 16); sel_down;
      sel_up;
      chk("R8", {30'd0, sdo_en, sdo}, 32'h2, "busy status");
      bitx(1'b1, o, oe);
      chk("R9", {30'd0, oe, o}, 32'h2, "1 while busy ignored");
      while (pg_busy) @(negedge clk);
      repeat (4) @(negedge clk);
      chk("R8", {30'd0, sdo_en, sdo}, 32'h3, "ready status");
      bitx(1'b1, o, oe);
      chk("R9", {31'd0, oe}, 32'd0, "status off after ready 1");
      sel_down;

      // erase one, erase all, write all (R5 sub-codes, R6 kinds)
      exp_q.push_back('{k: 2'd1, a: 7'h2A, d: 16'h0});
      sel_up; cmd(2'b11, 7'h2A, 6); sel_down; finish_req;
      exp_q.push_back('{k: 2'd2, a: 7'h0, d: 16'h0});
      sel_up; cmd(2'b00, 7'b0100000, 6); sel_down; finish_req;
      exp_q.push_back('{k: 2'd3, a: 7'h0, d: 16'h1234});
      sel_up; cmd(2'b00, 7'b0010000, 6); send_bits(32'h1234, 16); sel_down; finish_req;

      // R7: truncated write is dropped, next frame decodes
      sel_up; cmd(2'b01, 7'd4, 6); send_bits(32'h15, 5); sel_down;
      repeat (10) @(negedge clk);
      sel_up;
      chk("R7", {31'd0, sdo_en}, 32'd0, "no status after truncated frame");
      sel_down;
      exp_q.push_back('{k: 2'd1, a: 7'd3, d: 16'h0});
      sel_up; cmd(2'b11, 7'd3, 6); sel_down; finish_req;

      // R5: disable, then erase is refused; R11 read still works
      sel_up; cmd(2'b00, 7'b0000000, 6); sel_down;
      sel_up; cmd(2'b11, 7'd1, 6); sel_down;
      repeat (10) @(negedge clk);
      sel_up;
      chk("R5", {31'd0, sdo_en}, 32'd0, "erase refused after disable");
      start_read(7'd2, 6, "R11");
      rd_word(16, w); chk("R11", 32'(w), 32'(patt(2)), "read with writes disabled");
      sel_down;

      // R1: 8-bit organisation, read wrap and write
      org_wide = 1'b0;
      repeat (4) @(negedge clk);
      sel_up;
      start_read(7'd127, 7, "R1");
      rd_word(8, w); chk("R1", 32'(w), 32'(patt(127) & 16'hFF), "byte at 127");
      rd_word(8, w); chk("R4", 32'(w), 32'(patt(0) & 16'hFF), "byte wrap to 0");
      sel_down;
      sel_up; cmd(2'b00, 7'b1100000, 7); sel_down;
      exp_q.push_back('{k: 2'd0, a: 7'h45, d: 16'h007E});
      sel_up; cmd(2'b01, 7'h45, 7); send_bits(32'h7E, 8); sel_down; finish_req;

      // R10: deselect in the middle of a read
      sel_up;
      start_read(7'd1, 7, "R3");
      send_bits(32'd0, 3);
      sel_down;
      chk("R10", {31'd0, sdo_en}, 32'd0, "sdo_en off mid-read");

      repeat (20) @(negedge clk);
      chk("R6", 32'(exp_q.size()), 32'd0, "expected requests left over");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule